// File: doc/BRIEF.md
# Encoded-Time Control Sequencer

This block produces the timed control strobes that move data inside a small processor. A free-running two-bit time counter advances on every master clock. One shared decoder turns the counter value into four one-hot time slots, and every sequencer reuses those slots. Each sequencer forms its active-low control outputs as a sum of slots, and it only drives them while its own start strobe is high. Two sequences are provided. The first is a register-to-register move: the source register drives the data bus and the destination register loads. The second is an indirect memory read: a pointer register drives the address bus, memory is read, and the destination register loads.

The counter value is visible on the `et` output so that other logic can follow the same time base. At most one start strobe may be high at a time. If both are high, the block raises `strobe_clash` and holds every control output inactive (high). The block has no data streams. All of its pins are plain control and status pins, so no valid/ready handshake applies and there is no back-pressure. At a 4 MHz master clock each slot lasts 250 ns, so the three-slot read sequence spans 750 ns.

Top module: `etime_ctrl_seq`

## Requirements
- R1: When reset is low, the time counter `et` increases by one on every rising clock edge and wraps from 3 to 0.
- R2: A synchronous active-high reset `rst` sets `et` to 0 (slot T1) at the next rising edge and holds it there while reset stays high.
- R3: The slot encoding is fixed: `et` = 0 is T1, 1 is T2, 2 is T3 and 3 is T4. All sequence timings below use these slots.
- R4: While only `rd_go` is high, `rd_ptr_addr_n` is low in T1, T2 and T3, `rd_mem_rd_n` is low in T2 and T3, and `rd_dst_ld_n` is low in T3 only. Each of them is high in every other slot.
- R5: While only `mv_go` is high, `mv_src_drv_n` is low in T1 and T2, and `mv_dst_ld_n` is low in T2 only. Both are released (high) in T3 and T4.
- R6: Every control output is active low. When neither strobe is high, all five control outputs are high.
- R7: A sequencer's outputs stay high whenever its own strobe is low, whatever the other sequencer is doing.
- R8: When both strobes are high, `strobe_clash` is 1 and all five control outputs are high. Otherwise `strobe_clash` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mv_go | input | 1 | Start strobe for the register-move sequence |
| rd_go | input | 1 | Start strobe for the indirect-read sequence |
| et | output | 2 | Encoded time counter value (slot index) |
| mv_src_drv_n | output | 1 | Move: source register drives the data bus, active low |
| mv_dst_ld_n | output | 1 | Move: destination register load, active low |
| rd_ptr_addr_n | output | 1 | Read: pointer register drives the address bus, active low |
| rd_mem_rd_n | output | 1 | Read: memory read strobe, active low |
| rd_dst_ld_n | output | 1 | Read: destination register load, active low |
| strobe_clash | output | 1 | More than one strobe is high |

## Verification
The control outputs and `strobe_clash` are combinational in the strobes and the registered slot. A strobe change therefore shows up on them in the same cycle. The counter value itself moves only at a rising edge, so a reset takes effect one edge after it is applied. The bench drives inputs and compares outputs at the falling edge, when everything is settled. It keeps a behavioural slot model that advances at the rising edge. Each falling edge compares all seven outputs against that model for the current strobes, so every result is checked in the cycle it is due.

// File: rtl/etseq_pkg.sv
package etseq_pkg;
  // Slot names in counter order; the ordering is the encoding of R3.
  typedef enum logic [1:0] {
    SLOT_T1 = 2'd0,
    SLOT_T2 = 2'd1,
    SLOT_T3 = 2'd2,
    SLOT_T4 = 2'd3
  } slot_e;

  localparam int SEQ_MOVE = 0;
  localparam int SEQ_READ = 1;

  // Bit i of a mask selects slot T(i+1).
  function automatic logic [3:0] slot_span(input int first, input int last);
    logic [3:0] m;
    m = '0;
    for (int i = 0; i < 4; i++) begin
      if (i >= first && i <= last) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/et_counter.sv
module et_counter #(
  parameter int ET_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  output logic [ET_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == ET_W'($past(cnt) + 1'b1));

  a_r2_reset_t1: assert property (@(posedge clk)
    rst |=> cnt == '0);
endmodule

// File: rtl/slot_decoder.sv
module slot_decoder #(
  parameter int ET_W  = 2,
  localparam int SLOTS = 1 << ET_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ET_W-1:0]  et,
  output logic [SLOTS-1:0] slot
);
  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_prod
      assign slot[g] = (et == ET_W'(g));
    end
  endgenerate

  a_r3_one_slot: assert property (@(posedge clk) disable iff (rst)
    $countones(slot) == 1 && slot[et]);
endmodule

// File: rtl/strobe_guard.sv
module strobe_guard #(
  parameter int NSEQ = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSEQ-1:0] go,
  output logic [NSEQ-1:0] en,
  output logic            clash
);
  always_comb begin
    clash = ($countones(go) > 1);
    en    = clash ? '0 : go;
  end

  a_r8_enable_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en));
  a_r7_enable_needs_go: assert property (@(posedge clk) disable iff (rst)
    (en & ~go) == '0);
endmodule

// File: rtl/seq_unit.sv
module seq_unit #(
  parameter int NOUT  = 2,
  parameter int SLOTS = 4,
  parameter logic [NOUT*SLOTS-1:0] MASKS = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] slot,
  input  logic             en,
  output logic [NOUT-1:0]  ctl_n
);
  genvar g;
  generate
    for (g = 0; g < NOUT; g++) begin : g_sum
      localparam logic [SLOTS-1:0] SEL = MASKS[g*SLOTS +: SLOTS];
      assign ctl_n[g] = ~(en & |(slot & SEL));
    end
  endgenerate

  a_r7_idle_released: assert property (@(posedge clk) disable iff (rst)
    !en |-> &ctl_n);
endmodule

// File: rtl/etime_ctrl_seq.sv
module etime_ctrl_seq #(
  parameter int ET_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mv_go,
  input  logic            rd_go,
  output logic [ET_W-1:0] et,
  output logic            mv_src_drv_n,
  output logic            mv_dst_ld_n,
  output logic            rd_ptr_addr_n,
  output logic            rd_mem_rd_n,
  output logic            rd_dst_ld_n,
  output logic            strobe_clash
);
  import etseq_pkg::*;

  localparam int SLOTS = 1 << ET_W;
  localparam int NSEQ  = 2;

  // Move: out0 = source drive (T1..T2), out1 = destination load (T2).
  localparam logic [2*SLOTS-1:0] MV_MASKS =
    {SLOTS'(slot_span(1, 1)), SLOTS'(slot_span(0, 1))};
  // Read: out0 = pointer address (T1..T3), out1 = memory read (T2..T3),
  //       out2 = destination load (T3).
  localparam logic [3*SLOTS-1:0] RD_MASKS =
    {SLOTS'(slot_span(2, 2)), SLOTS'(slot_span(1, 2)), SLOTS'(slot_span(0, 2))};

  logic [SLOTS-1:0] slot;
  logic [NSEQ-1:0]  go, en;
  logic [1:0]       mv_ctl_n;
  logic [2:0]       rd_ctl_n;

  et_counter #(.ET_W(ET_W)) u_cnt (.clk(clk), .rst(rst), .cnt(et));

  slot_decoder #(.ET_W(ET_W)) u_dec (
    .clk(clk), .rst(rst), .et(et), .slot(slot));

  assign go[SEQ_MOVE] = mv_go;
  assign go[SEQ_READ] = rd_go;

  strobe_guard #(.NSEQ(NSEQ)) u_guard (
    .clk(clk), .rst(rst), .go(go), .en(en), .clash(strobe_clash));

  seq_unit #(.NOUT(2), .SLOTS(SLOTS), .MASKS(MV_MASKS)) u_mv (
    .clk(clk), .rst(rst), .slot(slot), .en(en[SEQ_MOVE]), .ctl_n(mv_ctl_n));

  seq_unit #(.NOUT(3), .SLOTS(SLOTS), .MASKS(RD_MASKS)) u_rd (
    .clk(clk), .rst(rst), .slot(slot), .en(en[SEQ_READ]), .ctl_n(rd_ctl_n));

  assign mv_src_drv_n  = mv_ctl_n[0];
  assign mv_dst_ld_n   = mv_ctl_n[1];
  assign rd_ptr_addr_n = rd_ctl_n[0];
  assign rd_mem_rd_n   = rd_ctl_n[1];
  assign rd_dst_ld_n   = rd_ctl_n[2];

  a_r4_read_nesting: assert property (@(posedge clk) disable iff (rst)
    (!rd_mem_rd_n |-> !rd_ptr_addr_n) and (!rd_dst_ld_n |-> !rd_mem_rd_n));

  a_r5_move_load_inside_drive: assert property (@(posedge clk) disable iff (rst)
    !mv_dst_ld_n |-> !mv_src_drv_n);

  a_r8_clash_quiet: assert property (@(posedge clk) disable iff (rst)
    strobe_clash |-> (mv_src_drv_n && mv_dst_ld_n && rd_ptr_addr_n &&
                      rd_mem_rd_n && rd_dst_ld_n));

  a_r6_no_cross_drive: assert property (@(posedge clk) disable iff (rst)
    !(!mv_src_drv_n && !rd_ptr_addr_n));
endmodule

// File: tb/etime_ctrl_seq_test.sv
`timescale 1ns/100ps
module etime_ctrl_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mv_go = 1'b0, rd_go = 1'b0;
  logic [1:0] et;
  logic mv_src_drv_n, mv_dst_ld_n, rd_ptr_addr_n, rd_mem_rd_n, rd_dst_ld_n;
  logic strobe_clash;

  int vectors = 0;
  int misses  = 0;
  int model_slot = 0;

  always #2.5 clk = ~clk;

  etime_ctrl_seq uut (
    .clk(clk), .rst(rst), .mv_go(mv_go), .rd_go(rd_go), .et(et),
    .mv_src_drv_n(mv_src_drv_n), .mv_dst_ld_n(mv_dst_ld_n),
    .rd_ptr_addr_n(rd_ptr_addr_n), .rd_mem_rd_n(rd_mem_rd_n),
    .rd_dst_ld_n(rd_dst_ld_n), .strobe_clash(strobe_clash));

  // Behavioural time model: slot index 0..3 is T1..T4.
  always @(posedge clk) begin
    if (rst) model_slot <= 0;
    else     model_slot <= (model_slot + 1) % 4;
  end

  task automatic chk(input string tag, input string name, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: got %0d expected %0d (slot %0d, mv_go %0b, rd_go %0b)",
               tag, name, act, exp, model_slot, mv_go, rd_go);
    end
  endtask

  task automatic compare_all();
    bit both, mv, rd;
    string mtag, rtag;
    both = mv_go && rd_go;
    mv   = mv_go && !both;
    rd   = rd_go && !both;
    mtag = both ? "R8" : (mv ? "R5" : (rd_go ? "R7" : "R6"));
    rtag = both ? "R8" : (rd ? "R4" : (mv_go ? "R7" : "R6"));
    chk(rst ? "R2" : "R1 R3", "et", int'(et), model_slot);
    chk("R8", "strobe_clash", int'(strobe_clash), int'(both));
    chk(mtag, "mv_src_drv_n",  int'(mv_src_drv_n),  int'(!(mv && model_slot <= 1)));
    chk(mtag, "mv_dst_ld_n",   int'(mv_dst_ld_n),   int'(!(mv && model_slot == 1)));
    chk(rtag, "rd_ptr_addr_n", int'(rd_ptr_addr_n), int'(!(rd && model_slot <= 2)));
    chk(rtag, "rd_mem_rd_n",   int'(rd_mem_rd_n),   int'(!(rd && (model_slot == 1 || model_slot == 2))));
    chk(rtag, "rd_dst_ld_n",   int'(rd_dst_ld_n),   int'(!(rd && model_slot == 2)));
  endtask

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    repeat (3) @(negedge clk);
    // R2: counter at T1 after reset edges
    chk("R2", "et after reset", int'(et), 0);
    rst = 1'b0;
    for (int c = 0; c < 260; c++) begin
      @(negedge clk);
      compare_all();
      // next stimulus
      rst = (c == 120 || c == 121);
      if (c < 8)        begin mv_go = 0; rd_go = 0; end
      else if (c < 16)  begin mv_go = 1; rd_go = 0; end
      else if (c < 24)  begin mv_go = 0; rd_go = 1; end
      else if (c < 30)  begin mv_go = 1; rd_go = 1; end
      else if (c < 40)  begin mv_go = c[0]; rd_go = ~c[0]; end
      else begin
        lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mv_go = lfsr[0];
        rd_go = lfsr[3];
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #20000;
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule